// File: doc/BRIEF.md
# Priority-Based Clock Reference Selector

The block picks one active clock reference out of a parameterised set (four by default) and reports which one it is. Each reference contributes three live status inputs (signal present, masked, frequency offset acceptable), and the block also holds a small priority and revertive configuration for each reference. A reference is usable only when its signal is present, it is not masked and its offset is acceptable. In automatic mode the block ranks the usable references by priority value, where 0 is best and ties go to the lower reference number. It moves to the best usable one when the active reference drops out. It returns to a better-ranked reference only when the reference it is leaving is marked revertive.

In manual mode the host names the reference directly, and the priority fields stop taking writes. The revertive bits stay writable. The outputs are the active index, a flag that says whether the active reference is usable, and a one-cycle pulse on every change of index. All outputs are registered. The status inputs sampled at a clock edge are reflected in the outputs right after that edge.

Top module: `ref_priority_selector`

## Requirements
- R1: Reference k is usable only when `sig_present[k]`=1, `ref_mask[k]`=0 and `offset_ok[k]`=1. If any one of these conditions fails, reference k is never picked in automatic mode.
- R2: Ranking compares the 3-bit priority values, where the lower value ranks higher. When two priorities are equal, the lower reference number ranks higher.
- R3: In automatic mode, if the active reference is not usable at an edge and some reference is usable, `active_idx` becomes the best-ranked usable reference after that edge, with `active_valid`=1.
- R4: In automatic mode, if no reference is usable at an edge, `active_idx` keeps its value and `active_valid` becomes 0 after that edge.
- R5: In automatic mode, while the active reference stays usable, the block moves to a better-ranked usable reference only if the revertive bit of the active reference is 1. Otherwise the index holds.
- R6: When `active_valid` is 0 (after reset or after a total loss) and some reference is usable in automatic mode, the best-ranked one is taken at the next edge, whatever the revertive bits are.
- R7: With `manual_mode`=1, `active_idx` follows `manual_sel` after each edge, and `active_valid` shows whether that reference is usable.
- R8: A configuration write (`cfg_we`=1) sets the revertive bit of reference `cfg_idx` in either mode. It updates the priority only when `manual_mode`=0. `prio_rd` holds the priority of reference k at bits [3k+2:3k], and `revert_rd[k]` holds its revertive bit.
- R9: Reset gives every priority 0, every revertive bit 0, `active_idx`=0, `active_valid`=0 and `switch_pulse`=0.
- R10: `switch_pulse` is 1 for exactly the cycle that follows an edge at which `active_idx` changed, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| manual_mode | input | 1 | 1 selects manual selection, 0 selects automatic |
| manual_sel | input | 2 | Reference chosen in manual mode |
| sig_present | input | 4 | Per-reference signal present |
| ref_mask | input | 4 | Per-reference mask, 1 excludes the reference |
| offset_ok | input | 4 | Per-reference frequency offset acceptable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Reference addressed by the write |
| cfg_prio | input | 3 | Priority value to write |
| cfg_revert | input | 1 | Revertive bit to write |
| active_idx | output | 2 | Index of the active reference |
| active_valid | output | 1 | The active reference is usable |
| switch_pulse | output | 1 | One-cycle pulse on a change of index |
| prio_rd | output | 12 | Stored priorities, 3 bits per reference |
| revert_rd | output | 4 | Stored revertive bits |

## Verification
The assertions assume that every input is synchronous to `clk` and settles well before each rising edge. They also assume that `manual_sel` and `cfg_idx` always name an existing reference, which holds because the reference count must be a power of two. The bench changes inputs 1 ns after a rising edge and samples outputs at the same point. It never applies a status change and a configuration write for an affected reference at the same edge, so each expected index depends on a single cause.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

   // Selection mode: automatic ranking or host-forced index.
   typedef enum logic [0:0] {
      SEL_AUTO   = 1'b0,
      SEL_MANUAL = 1'b1
   } sel_mode_e;

endpackage

// File: rtl/refsel_cfg_regs.sv
module refsel_cfg_regs
   import refsel_pkg::*;
#(
   parameter int NUM_REFS = 4,
   parameter int PRIO_W   = 3,
   parameter int IDX_W    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  sel_mode_e                         mode,
   input  logic                              we,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [PRIO_W-1:0]                 wr_prio,
   input  logic                              wr_revert,
   output logic [NUM_REFS-1:0][PRIO_W-1:0]   prio,
   output logic [NUM_REFS-1:0]               revert
);

   logic [NUM_REFS-1:0][PRIO_W-1:0] prio_r;
   logic [NUM_REFS-1:0]             revert_r;

   for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
      logic hit;
      assign hit = we && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_r[g]   <= '0;
            revert_r[g] <= 1'b0;
         end else if (hit) begin
            revert_r[g] <= wr_revert;
            if (mode == SEL_AUTO) begin
               prio_r[g] <= wr_prio;
            end
         end
      end
   end

   assign prio   = prio_r;
   assign revert = revert_r;

   // R8: priorities are frozen while manual mode is selected
   a_r8_prio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_MANUAL) |=> $stable(prio_r));

   // R8: a write in automatic mode lands in the addressed priority field
   a_r8_prio_written: assert property (@(posedge clk) disable iff (!rst_n)
      (we && mode == SEL_AUTO) |=> (prio_r[$past(wr_idx)] == $past(wr_prio)));

endmodule

// File: rtl/refsel_ranker.sv
module refsel_ranker #(
   parameter int NUM_REFS    = 4,
   parameter int PRIO_W      = 3,
   parameter int IDX_W       = 2,
   parameter bit COMPARE_KEY = 1'b1
) (
   input  logic [NUM_REFS-1:0]              avail,
   input  logic [NUM_REFS-1:0][PRIO_W-1:0]  prio,
   output logic                             any_avail,
   output logic [IDX_W-1:0]                 best_idx,
   output logic [PRIO_W-1:0]                best_prio
);

   localparam int KEY_W = PRIO_W + IDX_W;

   // Running winner carried from reference 0 upward; stage g holds the
   // best of references 0..g-1.
   logic [NUM_REFS:0]              found_c;
   logic [NUM_REFS:0][IDX_W-1:0]   idx_c;
   logic [NUM_REFS:0][PRIO_W-1:0]  prio_c;

   assign found_c[0] = 1'b0;
   assign idx_c[0]   = '0;
   assign prio_c[0]  = '0;

   for (genvar g = 0; g < NUM_REFS; g++) begin : g_stage
      logic take;
      if (COMPARE_KEY) begin : g_key
         // Full rank key: priority then index, lower key wins.
         logic [KEY_W-1:0] key_new;
         logic [KEY_W-1:0] key_old;
         assign key_new = {prio[g], IDX_W'(g)};
         assign key_old = {prio_c[g], idx_c[g]};
         assign take    = avail[g] && (!found_c[g] || (key_new < key_old));
      end else begin : g_prio
         // Strictly better priority only; earlier (lower) index keeps ties.
         assign take = avail[g] && (!found_c[g] || (prio[g] < prio_c[g]));
      end
      assign found_c[g+1] = found_c[g] | avail[g];
      assign idx_c[g+1]   = take ? IDX_W'(g) : idx_c[g];
      assign prio_c[g+1]  = take ? prio[g]   : prio_c[g];
   end

   assign any_avail = found_c[NUM_REFS];
   assign best_idx  = idx_c[NUM_REFS];
   assign best_prio = prio_c[NUM_REFS];

   always_comb begin
      if (any_avail) begin
         // R1: the winner is always a usable reference
         a_r1_best_usable: assert (avail[best_idx]);
      end
      for (int i = 0; i < NUM_REFS; i++) begin
         if (avail[i]) begin
            // R2: no usable reference carries a better priority than the winner
            a_r2_best_ranked: assert (prio[i] >= best_prio);
            // R2: on an equal priority the winner has the lower index
            if (prio[i] == best_prio) begin
               a_r2_tie_low_index: assert (IDX_W'(i) >= best_idx);
            end
         end
      end
   end

endmodule

// File: rtl/refsel_tracker.sv
module refsel_tracker
   import refsel_pkg::*;
#(
   parameter int NUM_REFS = 4,
   parameter int PRIO_W   = 3,
   parameter int IDX_W    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  sel_mode_e                         mode,
   input  logic [IDX_W-1:0]                  manual_sel,
   input  logic [NUM_REFS-1:0]               avail,
   input  logic [NUM_REFS-1:0][PRIO_W-1:0]   prio,
   input  logic [NUM_REFS-1:0]               revert,
   input  logic                              any_avail,
   input  logic [IDX_W-1:0]                  best_idx,
   input  logic [PRIO_W-1:0]                 best_prio,
   output logic [IDX_W-1:0]                  idx_q,
   output logic                              valid_q,
   output logic                              pulse_q
);

   logic [IDX_W-1:0]  idx_d;
   logic              valid_d;
   logic [PRIO_W-1:0] cur_prio;
   logic              cur_usable;
   logic              best_outranks;

   assign cur_prio   = prio[idx_q];
   assign cur_usable = avail[idx_q];

   // Rank comparison of the candidate against the active reference.
   assign best_outranks = (best_prio < cur_prio) ||
                          ((best_prio == cur_prio) && (best_idx < idx_q));

   always_comb begin
      idx_d   = idx_q;
      valid_d = valid_q;
      unique case (mode)
         SEL_MANUAL: begin
            idx_d   = manual_sel;
            valid_d = avail[manual_sel];
         end
         SEL_AUTO: begin
            if (!any_avail) begin
               valid_d = 1'b0;
            end else if (!valid_q || !cur_usable) begin
               idx_d   = best_idx;
               valid_d = 1'b1;
            end else if (revert[idx_q] && best_outranks) begin
               idx_d   = best_idx;
               valid_d = 1'b1;
            end else begin
               valid_d = 1'b1;
            end
         end
         default: begin
            valid_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         valid_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         idx_q   <= idx_d;
         valid_q <= valid_d;
         pulse_q <= (idx_d != idx_q);
      end
   end

   // R4: no usable reference drops the valid flag and holds the index
   a_r4_loss_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_AUTO && avail == '0) |=> (!valid_q && $stable(idx_q)));

   // R6: any usable reference in automatic mode gives a valid selection
   a_r6_take_first: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_AUTO && avail != '0) |=> valid_q);

   // R5: an active, usable, non-revertive reference is never left
   a_r5_non_revertive_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_AUTO && valid_q && avail[idx_q] && !revert[idx_q])
      |=> $stable(idx_q));

   // R7: manual mode follows the host choice
   a_r7_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_MANUAL) |=> (idx_q == $past(manual_sel)));

   // R10: the pulse marks exactly the cycles after an index change
   a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> (idx_q != $past(idx_q)));

   a_r10_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q != $past(idx_q)) |-> pulse_q);

endmodule

// File: rtl/ref_priority_selector.sv
module ref_priority_selector
   import refsel_pkg::*;
#(
   parameter int NUM_REFS    = 4,
   parameter int PRIO_W      = 3,
   parameter bit COMPARE_KEY = 1'b1,
   localparam int IDX_W      = $clog2(NUM_REFS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         manual_mode,
   input  logic [IDX_W-1:0]             manual_sel,
   input  logic [NUM_REFS-1:0]          sig_present,
   input  logic [NUM_REFS-1:0]          ref_mask,
   input  logic [NUM_REFS-1:0]          offset_ok,
   input  logic                         cfg_we,
   input  logic [IDX_W-1:0]             cfg_idx,
   input  logic [PRIO_W-1:0]            cfg_prio,
   input  logic                         cfg_revert,
   output logic [IDX_W-1:0]             active_idx,
   output logic                         active_valid,
   output logic                         switch_pulse,
   output logic [NUM_REFS*PRIO_W-1:0]   prio_rd,
   output logic [NUM_REFS-1:0]          revert_rd
);

   // Elaboration-time parameter checks.
   if (NUM_REFS < 2 || (NUM_REFS & (NUM_REFS - 1)) != 0) begin : g_bad_refs
      $error("NUM_REFS must be a power of two of at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie between 1 and 8");
   end

   sel_mode_e                        mode;
   logic [NUM_REFS-1:0]              avail;
   logic [NUM_REFS-1:0][PRIO_W-1:0]  prio;
   logic [NUM_REFS-1:0]              revert;
   logic                             any_avail;
   logic [IDX_W-1:0]                 best_idx;
   logic [PRIO_W-1:0]                best_prio;

   assign mode  = manual_mode ? SEL_MANUAL : SEL_AUTO;
   // R1: usable means present, unmasked and within offset
   assign avail = sig_present & ~ref_mask & offset_ok;

   refsel_cfg_regs #(
      .NUM_REFS (NUM_REFS),
      .PRIO_W   (PRIO_W),
      .IDX_W    (IDX_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .we        (cfg_we),
      .wr_idx    (cfg_idx),
      .wr_prio   (cfg_prio),
      .wr_revert (cfg_revert),
      .prio      (prio),
      .revert    (revert)
   );

   refsel_ranker #(
      .NUM_REFS    (NUM_REFS),
      .PRIO_W      (PRIO_W),
      .IDX_W       (IDX_W),
      .COMPARE_KEY (COMPARE_KEY)
   ) u_rank (
      .avail     (avail),
      .prio      (prio),
      .any_avail (any_avail),
      .best_idx  (best_idx),
      .best_prio (best_prio)
   );

   refsel_tracker #(
      .NUM_REFS (NUM_REFS),
      .PRIO_W   (PRIO_W),
      .IDX_W    (IDX_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .manual_sel (manual_sel),
      .avail      (avail),
      .prio       (prio),
      .revert     (revert),
      .any_avail  (any_avail),
      .best_idx   (best_idx),
      .best_prio  (best_prio),
      .idx_q      (active_idx),
      .valid_q    (active_valid),
      .pulse_q    (switch_pulse)
   );

   assign prio_rd   = prio;
   assign revert_rd = revert;

   // R3: losing the active reference while another is usable moves to the winner
   a_r3_failover: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_AUTO && active_valid && !avail[active_idx] && any_avail)
      |=> (active_valid && active_idx == $past(best_idx)));

endmodule

// File: tb/ref_priority_selector_bench.sv
module ref_priority_selector_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        manual_mode = 1'b0;
   logic [1:0]  manual_sel = '0;
   logic [3:0]  sig_present = '0;
   logic [3:0]  ref_mask = '0;
   logic [3:0]  offset_ok = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [2:0]  cfg_prio = '0;
   logic        cfg_revert = 1'b0;
   logic [1:0]  active_idx;
   logic        active_valid;
   logic        switch_pulse;
   logic [11:0] prio_rd;
   logic [3:0]  revert_rd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ref_priority_selector u_ref_priority_selector (
      .clk          (clk),
      .rst_n        (rst_n),
      .manual_mode  (manual_mode),
      .manual_sel   (manual_sel),
      .sig_present  (sig_present),
      .ref_mask     (ref_mask),
      .offset_ok    (offset_ok),
      .cfg_we       (cfg_we),
      .cfg_idx      (cfg_idx),
      .cfg_prio     (cfg_prio),
      .cfg_revert   (cfg_revert),
      .active_idx   (active_idx),
      .active_valid (active_valid),
      .switch_pulse (switch_pulse),
      .prio_rd      (prio_rd),
      .revert_rd    (revert_rd)
   );

   // Vector layout: {present[3:0], mask[3:0], offset_ok[3:0], exp_valid, exp_idx[1:0]}
   // Bit k of each nibble is reference k. Priorities: ref0=3 ref1=1 ref2=1 ref3=0.
   // Revertive: ref0=1 ref1=0 ref2=1 ref3=0.
   localparam int NVEC = 12;
   localparam logic [14:0] VEC [NVEC] = '{
      {4'b0001, 4'b0000, 4'b1111, 1'b1, 2'd0},  // R6 first usable taken
      {4'b0011, 4'b0000, 4'b1111, 1'b1, 2'd1},  // R5 ref0 revertive, ref1 better
      {4'b0111, 4'b0000, 4'b1111, 1'b1, 2'd1},  // R2 tie ref1/ref2, stay
      {4'b1111, 4'b0000, 4'b1111, 1'b1, 2'd1},  // R5 ref3 better, ref1 non-revertive
      {4'b1111, 4'b0010, 4'b1111, 1'b1, 2'd3},  // R1 mask drops ref1, R3 to ref3
      {4'b1111, 4'b0000, 4'b1111, 1'b1, 2'd3},  // R5 ref3 already best, hold
      {4'b1111, 4'b0000, 4'b0111, 1'b1, 2'd1},  // R1 offset drops ref3, R2 tie to ref1
      {4'b1011, 4'b0000, 4'b1111, 1'b1, 2'd1},  // R5 ref3 returns, no revert
      {4'b1001, 4'b0000, 4'b1111, 1'b1, 2'd3},  // R1 absent ref1, R3 to ref3
      {4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd3},  // R4 none usable
      {4'b0101, 4'b0000, 4'b1111, 1'b1, 2'd2},  // R6 reacquire best
      {4'b1101, 4'b0000, 4'b1111, 1'b1, 2'd3}   // R5 ref2 revertive, go to ref3
   };

   function automatic string vec_tag(int i);
      case (i)
         0, 10:      return "R6";
         1, 3, 5, 7: return "R5";
         2:          return "R2";
         4, 8:       return "R1/R3";
         6:          return "R1/R2";
         9:          return "R4";
         default:    return "R5";
      endcase
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg_write(logic [1:0] idx, logic [2:0] p, logic rv);
      cfg_we     = 1'b1;
      cfg_idx    = idx;
      cfg_prio   = p;
      cfg_revert = rv;
      step();
      cfg_we     = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] prev_idx;
      repeat (3) @(posedge clk);
      #1;
      check("R9", "reset idx", 32'(active_idx), 0);
      check("R9", "reset valid", 32'(active_valid), 0);
      check("R9", "reset pulse", 32'(switch_pulse), 0);
      check("R9", "reset prio", 32'(prio_rd), 0);
      check("R9", "reset revert", 32'(revert_rd), 0);
      rst_n = 1'b1;
      step();
      check("R4", "idle valid", 32'(active_valid), 0);

      cfg_write(2'd0, 3'd3, 1'b1);
      cfg_write(2'd1, 3'd1, 1'b0);
      cfg_write(2'd2, 3'd1, 1'b1);
      cfg_write(2'd3, 3'd0, 1'b0);
      check("R8", "auto prio write", 32'(prio_rd), 32'({3'd0, 3'd1, 3'd1, 3'd3}));
      check("R8", "auto revert write", 32'(revert_rd), 32'(4'b0101));

      prev_idx = active_idx;
      for (int i = 0; i < NVEC; i++) begin
         logic [14:0] v;
         v = VEC[i];
         sig_present = v[14:11];
         ref_mask    = v[10:7];
         offset_ok   = v[6:3];
         step();
         check(vec_tag(i), $sformatf("vec %0d idx", i), 32'(active_idx), 32'(v[1:0]));
         check(vec_tag(i), $sformatf("vec %0d valid", i), 32'(active_valid), 32'(v[2]));
         check("R10", $sformatf("vec %0d pulse", i), 32'(switch_pulse),
               32'(v[1:0] != prev_idx));
         prev_idx = v[1:0];
      end

      // R10: pulse lasts one cycle only
      step();
      check("R10", "pulse clears", 32'(switch_pulse), 0);
      check("R5", "idx held", 32'(active_idx), 3);

      // R7: manual mode forces the index
      manual_mode = 1'b1;
      manual_sel  = 2'd1;
      sig_present = 4'b1111;
      step();
      check("R7", "manual idx", 32'(active_idx), 1);
      check("R7", "manual valid", 32'(active_valid), 1);
      check("R10", "manual pulse", 32'(switch_pulse), 1);

      // R8: priority write ignored in manual, revertive accepted
      cfg_write(2'd1, 3'd7, 1'b1);
      check("R8", "manual prio frozen", 32'(prio_rd), 32'({3'd0, 3'd1, 3'd1, 3'd3}));
      check("R8", "manual revert write", 32'(revert_rd), 32'(4'b0111));
      check("R10", "no change no pulse", 32'(switch_pulse), 0);

      // R7: manual choice of an unusable reference
      manual_sel  = 2'd0;
      sig_present = 4'b1110;
      step();
      check("R7", "manual idx unusable", 32'(active_idx), 0);
      check("R7", "manual valid unusable", 32'(active_valid), 0);

      // R6: back in automatic with no valid selection, best is taken
      manual_mode = 1'b0;
      step();
      check("R6", "auto reacquire idx", 32'(active_idx), 3);
      check("R6", "auto reacquire valid", 32'(active_valid), 1);

      // R8: priority writes accepted again
      cfg_write(2'd1, 3'd7, 1'b0);
      check("R8", "auto prio after manual", 32'(prio_rd), 32'({3'd0, 3'd1, 3'd7, 3'd3}));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule